// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches write cycles on a NOR-flash style memory bus and recognises the multi-write command sequences that start an erase. It handles two command grammars. In the normal grammar, a chip erase or sector erase takes six writes, and a three-write sequence enters a bypass mode. In the bypass grammar, two writes are enough for a chip erase, and a separate two-write sequence leaves the mode. When a sequence completes, the block raises a single-cycle command strobe together with a command code and the address of the final write.

An erase engine downstream consumes the strobe and reports back through `erase_busy`. While that input is high, the decoder discards every write except the suspend code, and it only accepts suspend in normal mode. A secured-region flag disables all bypass-mode writes. A synchronous bus strobe `wr_en` qualifies the address and the data. Only the low eight data bits carry command codes.

Top module: `flashcmd_decoder`

## Requirements
- R1: After reset `cmd_valid` is 0, `cmd_code` is 0, `cmd_addr` is 0 and `bypass_mode` is 0. A reset in the middle of a sequence discards the partial sequence and also clears bypass mode.
- R2: Six writes produce `cmd_valid`=1 with `cmd_code`=1 (chip erase): AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. No strobe appears on the first five writes.
- R3: The same first five writes followed by 30h at any address produce `cmd_code`=2 (sector erase), with `cmd_addr` equal to the address of that final write.
- R4: AAh@555h, 55h@2AAh, 20h@555h set `bypass_mode` to 1. In bypass mode, 90h followed by 00h (any addresses) clears it. No other writes leave the mode.
- R5: In bypass mode, 80h followed by 10h (any addresses) produces `cmd_code`=1 with no unlock writes. Outside bypass mode, the same two writes produce nothing.
- R6: A write that does not match the next expected step returns the decoder to the idle state of its current grammar and produces no strobe.
- R7: While `secure_en` is 1, every write in bypass mode is ignored. No strobe occurs and the sequence state and `bypass_mode` are unchanged.
- R8: While `erase_busy` is 1 in normal mode, a B0h write at any address produces `cmd_code`=3 (suspend). Every other write is discarded and leaves the sequence state unchanged.
- R9: In bypass mode there is no suspend: while `erase_busy` is 1, every write is discarded.
- R10: `cmd_valid` rises exactly one clock after the final write is sampled and lasts one cycle, unless another command completes. `cmd_addr` and `cmd_code` hold that command's values while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Write data; command codes in bits 7:0 |
| erase_busy | input | 1 | Erase engine is running |
| secure_en | input | 1 | Secured region enabled; blocks bypass writes |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 2 | 1 chip erase, 2 sector erase, 3 suspend |
| cmd_addr | output | AW | Address of the command's final write |
| bypass_mode | output | 1 | Decoder is in the bypass grammar |

## Verification
Every result is due one clock after the write that causes it. The bench drives each write on a falling edge and holds it through one rising edge. It then reads `cmd_valid`, `cmd_code`, `cmd_addr` and `bypass_mode` on the next falling edge, before any later write reaches the block. For intermediate writes the strobe is checked to be low at the same point.

Sweeps cover all 256 data values under `erase_busy` in both modes and under `secure_en` in bypass mode, a corrupted write at each of the six positions, and eight sector addresses.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

   typedef enum logic [1:0] {
      CMD_NONE    = 2'd0,
      CMD_CHIP    = 2'd1,
      CMD_SECTOR  = 2'd2,
      CMD_SUSPEND = 2'd3
   } cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_U1,
      ST_U2,
      ST_SETUP,
      ST_U3,
      ST_U4,
      ST_BP_IDLE,
      ST_BP_SETUP,
      ST_BP_EXIT
   } seq_e;

   localparam logic [7:0] D_UNLOCK1  = 8'hAA;
   localparam logic [7:0] D_UNLOCK2  = 8'h55;
   localparam logic [7:0] D_SETUP    = 8'h80;
   localparam logic [7:0] D_CHIP     = 8'h10;
   localparam logic [7:0] D_SECTOR   = 8'h30;
   localparam logic [7:0] D_BP_ENTER = 8'h20;
   localparam logic [7:0] D_BP_EXIT1 = 8'h90;
   localparam logic [7:0] D_BP_EXIT2 = 8'h00;
   localparam logic [7:0] D_SUSPEND  = 8'hB0;

endpackage

// File: rtl/flashcmd_match.sv
module flashcmd_match #(
   parameter int AW               = 12,
   parameter int UNLOCK_ADDR1     = 'h555,
   parameter int UNLOCK_ADDR2     = 'h2AA,
   parameter bit FULL_ADDR_DECODE = 1'b1
) (
   input  logic [AW-1:0] addr,
   output logic          at_a1,
   output logic          at_a2
);
   localparam int CMP_W = 11;
   localparam logic [AW-1:0] A1_FULL = AW'(UNLOCK_ADDR1);
   localparam logic [AW-1:0] A2_FULL = AW'(UNLOCK_ADDR2);

   generate
      if (FULL_ADDR_DECODE) begin : g_full
         assign at_a1 = (addr == A1_FULL);
         assign at_a2 = (addr == A2_FULL);
      end else begin : g_partial
         assign at_a1 = (addr[CMP_W-1:0] == A1_FULL[CMP_W-1:0]);
         assign at_a2 = (addr[CMP_W-1:0] == A2_FULL[CMP_W-1:0]);
      end
   endgenerate
endmodule

// File: rtl/flashcmd_seq.sv
module flashcmd_seq
   import flashcmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] code,
   input  logic       at_a1,
   input  logic       at_a2,
   input  logic       erase_busy,
   input  logic       secure_en,
   output logic       fire,
   output cmd_e       fire_code,
   output logic       in_bypass
);
   seq_e state, state_nx;
   logic is_bp;

   assign is_bp     = (state == ST_BP_IDLE) || (state == ST_BP_SETUP) ||
                      (state == ST_BP_EXIT);
   assign in_bypass = is_bp;

   always_comb begin
      state_nx  = state;
      fire      = 1'b0;
      fire_code = CMD_NONE;
      if (wr_en) begin
         if (erase_busy) begin
            if (!is_bp && code == D_SUSPEND) begin
               fire      = 1'b1;
               fire_code = CMD_SUSPEND;
            end
         end else if (!(is_bp && secure_en)) begin
            unique case (state)
               ST_IDLE:  state_nx = (at_a1 && code == D_UNLOCK1) ? ST_U1 : ST_IDLE;
               ST_U1:    state_nx = (at_a2 && code == D_UNLOCK2) ? ST_U2 : ST_IDLE;
               ST_U2: begin
                  if (at_a1 && code == D_SETUP)         state_nx = ST_SETUP;
                  else if (at_a1 && code == D_BP_ENTER) state_nx = ST_BP_IDLE;
                  else                                  state_nx = ST_IDLE;
               end
               ST_SETUP: state_nx = (at_a1 && code == D_UNLOCK1) ? ST_U3 : ST_IDLE;
               ST_U3:    state_nx = (at_a2 && code == D_UNLOCK2) ? ST_U4 : ST_IDLE;
               ST_U4: begin
                  state_nx = ST_IDLE;
                  if (at_a1 && code == D_CHIP) begin
                     fire      = 1'b1;
                     fire_code = CMD_CHIP;
                  end else if (code == D_SECTOR) begin
                     fire      = 1'b1;
                     fire_code = CMD_SECTOR;
                  end
               end
               ST_BP_IDLE: begin
                  if (code == D_SETUP)         state_nx = ST_BP_SETUP;
                  else if (code == D_BP_EXIT1) state_nx = ST_BP_EXIT;
                  else                         state_nx = ST_BP_IDLE;
               end
               ST_BP_SETUP: begin
                  state_nx = ST_BP_IDLE;
                  if (code == D_CHIP) begin
                     fire      = 1'b1;
                     fire_code = CMD_CHIP;
                  end
               end
               ST_BP_EXIT: state_nx = (code == D_BP_EXIT2) ? ST_IDLE : ST_BP_IDLE;
               default:    state_nx = ST_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end
endmodule

// File: rtl/flashcmd_out.sv
module flashcmd_out
   import flashcmd_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  cmd_e          fire_code,
   input  logic [AW-1:0] addr,
   output logic          cmd_valid,
   output logic [1:0]    cmd_code,
   output logic [AW-1:0] cmd_addr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_code  <= CMD_NONE;
         cmd_addr  <= '0;
      end else begin
         cmd_valid <= fire;
         if (fire) begin
            cmd_code <= fire_code;
            cmd_addr <= addr;
         end
      end
   end
endmodule

// File: rtl/flashcmd_decoder.sv
module flashcmd_decoder #(
   parameter int AW               = 12,
   parameter int DW               = 8,
   parameter int UNLOCK_ADDR1     = 'h555,
   parameter int UNLOCK_ADDR2     = 'h2AA,
   parameter bit FULL_ADDR_DECODE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          erase_busy,
   input  logic          secure_en,
   output logic          cmd_valid,
   output logic [1:0]    cmd_code,
   output logic [AW-1:0] cmd_addr,
   output logic          bypass_mode
);
   import flashcmd_pkg::*;

   localparam int CODE_W = 8;

   generate
      if (AW < 11) begin : g_bad_aw
         $error("flashcmd_decoder: AW must be at least 11");
      end
      if (DW < CODE_W) begin : g_bad_dw
         $error("flashcmd_decoder: DW must be at least 8");
      end
   endgenerate

   logic at_a1, at_a2, fire;
   cmd_e fire_code;

   flashcmd_match #(
      .AW(AW), .UNLOCK_ADDR1(UNLOCK_ADDR1), .UNLOCK_ADDR2(UNLOCK_ADDR2),
      .FULL_ADDR_DECODE(FULL_ADDR_DECODE)
   ) u_match (
      .addr(wr_addr), .at_a1(at_a1), .at_a2(at_a2)
   );

   flashcmd_seq u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .code(wr_data[CODE_W-1:0]),
      .at_a1(at_a1), .at_a2(at_a2), .erase_busy(erase_busy),
      .secure_en(secure_en), .fire(fire), .fire_code(fire_code),
      .in_bypass(bypass_mode)
   );

   flashcmd_out #(.AW(AW)) u_out (
      .clk(clk), .rst_n(rst_n), .fire(fire), .fire_code(fire_code),
      .addr(wr_addr), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_addr(cmd_addr)
   );
endmodule

// File: rtl/flashcmd_decoder_chk.sv
module flashcmd_decoder_chk #(
   parameter int AW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic          erase_busy,
   input logic          secure_en,
   input logic          cmd_valid,
   input logic [1:0]    cmd_code,
   input logic [AW-1:0] cmd_addr,
   input logic          bypass_mode
);
   a_r10_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(wr_en));

   a_r10_addr_from_final_write: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_addr == $past(wr_addr));

   a_r10_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_code != 2'd0);

   a_r8_busy_only_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && erase_busy) |=> (!cmd_valid || cmd_code == 2'd3));

   a_r9_no_suspend_in_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass_mode && erase_busy) |=> !cmd_valid);

   a_r7_secure_blocks_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass_mode && secure_en) |=> (!cmd_valid && bypass_mode));
endmodule

bind flashcmd_decoder flashcmd_decoder_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .erase_busy(erase_busy), .secure_en(secure_en), .cmd_valid(cmd_valid),
   .cmd_code(cmd_code), .cmd_addr(cmd_addr), .bypass_mode(bypass_mode)
);

// File: tb/flashcmd_decoder_tb.sv
module flashcmd_decoder_tb;
   localparam int AW = 12;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          erase_busy = 1'b0;
   logic          secure_en = 1'b0;
   logic          cmd_valid;
   logic [1:0]    cmd_code;
   logic [AW-1:0] cmd_addr;
   logic          bypass_mode;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   flashcmd_decoder #(.AW(AW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .erase_busy(erase_busy), .secure_en(secure_en),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
      .bypass_mode(bypass_mode)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive one write; returns on the falling edge after the sampling edge.
   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic unlock2();
      wr('h555, 'hAA); chk("R6 unlock1", int'(cmd_valid), 0);
      wr('h2AA, 'h55); chk("R6 unlock2", int'(cmd_valid), 0);
   endtask

   task automatic six(input int last_a, input int last_d);
      unlock2();
      wr('h555, 'h80); chk("R2 setup no strobe", int'(cmd_valid), 0);
      unlock2();
      wr(last_a, last_d);
   endtask

   initial begin
      int seq_a [6] = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA, 'h555};
      int seq_d [6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h10};

      do_reset();
      // R1 reset state
      chk("R1 valid", int'(cmd_valid), 0);
      chk("R1 code", int'(cmd_code), 0);
      chk("R1 addr", int'(cmd_addr), 0);
      chk("R1 bypass", int'(bypass_mode), 0);

      // R2 chip erase
      six('h555, 'h10);
      chk("R2 valid", int'(cmd_valid), 1);
      chk("R2 code", int'(cmd_code), 1);
      chk("R10 addr", int'(cmd_addr), 'h555);
      @(negedge clk);
      chk("R10 one cycle", int'(cmd_valid), 0);
      chk("R10 code held", int'(cmd_code), 1);

      // R3 sector erase sweep
      for (int i = 0; i < 8; i++) begin
         int sa;
         sa = i * 'h200 + i * 3;
         six(sa, 'h30);
         chk("R3 valid", int'(cmd_valid), 1);
         chk("R3 code", int'(cmd_code), 2);
         chk("R3 addr", int'(cmd_addr), sa);
      end

      // R6 corrupt each step position
      for (int p = 0; p < 6; p++) begin
         for (int s = 0; s < 6; s++) begin
            wr(seq_a[s], (s == p) ? (seq_d[s] ^ 1) : seq_d[s]);
            chk("R6 no strobe after mismatch", int'(cmd_valid), 0);
         end
         six('h555, 'h10);
         chk("R6 recovers", int'(cmd_valid), 1);
      end

      // R5 short erase outside bypass does nothing
      wr('h100, 'h80); wr('h100, 'h10);
      chk("R5 no bypass erase in normal", int'(cmd_valid), 0);

      // R4 bypass entry
      unlock2();
      wr('h555, 'h20);
      chk("R4 enter", int'(bypass_mode), 1);
      chk("R4 enter no strobe", int'(cmd_valid), 0);

      // R5 bypass chip erase
      wr('h123, 'h80);
      chk("R5 setup no strobe", int'(cmd_valid), 0);
      wr('h321, 'h10);
      chk("R5 valid", int'(cmd_valid), 1);
      chk("R5 code", int'(cmd_code), 1);
      chk("R5 addr", int'(cmd_addr), 'h321);

      // R4 six-cycle unlock writes do not leave bypass
      six('h555, 'h10);
      chk("R4 still bypass", int'(bypass_mode), 1);

      // R7 secure flag sweep in bypass
      secure_en = 1'b1;
      for (int d = 0; d < 256; d++) begin
         wr(d * 7, d);
         chk("R7 no strobe", int'(cmd_valid), 0);
         chk("R7 stays bypass", int'(bypass_mode), 1);
      end
      wr(0, 'h90); wr(0, 'h00);
      chk("R7 exit ignored", int'(bypass_mode), 1);
      wr(0, 'h80); wr(0, 'h10);
      chk("R7 erase ignored", int'(cmd_valid), 0);
      secure_en = 1'b0;
      wr(0, 'h80); wr(0, 'h10);
      chk("R7 after release", int'(cmd_valid), 1);

      // R9 no suspend in bypass
      erase_busy = 1'b1;
      for (int d = 0; d < 256; d++) begin
         wr('h555, d);
         chk("R9 discarded", int'(cmd_valid), 0);
      end
      erase_busy = 1'b0;
      chk("R9 bypass kept", int'(bypass_mode), 1);

      // R4 exit
      wr('h40, 'h90);
      chk("R4 exit step", int'(bypass_mode), 1);
      wr('h41, 'h00);
      chk("R4 exit", int'(bypass_mode), 0);
      wr(0, 'h80); wr(0, 'h10);
      chk("R4 short erase gone", int'(cmd_valid), 0);

      // R8 busy filter in normal mode, from mid-sequence
      unlock2();
      erase_busy = 1'b1;
      for (int d = 0; d < 256; d++) begin
         wr('h555, d);
         chk("R8 strobe only on suspend", int'(cmd_valid), (d == 'hB0) ? 1 : 0);
         if (d == 'hB0) chk("R8 code", int'(cmd_code), 3);
      end
      wr('h7AB, 'hB0);
      chk("R8 suspend addr", int'(cmd_addr), 'h7AB);
      erase_busy = 1'b0;
      wr('h555, 'h80); unlock2(); wr('h555, 'h10);
      chk("R8 state kept through busy", int'(cmd_valid), 1);

      // R1 reset mid-sequence
      unlock2(); wr('h555, 'h80);
      do_reset();
      unlock2(); wr('h555, 'h10);
      chk("R1 partial discarded", int'(cmd_valid), 0);
      unlock2(); wr('h555, 'h20);
      chk("R1 bypass before reset", int'(bypass_mode), 1);
      do_reset();
      chk("R1 bypass cleared", int'(bypass_mode), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule